// File: doc/BRIEF.md
# Write-Only Volatile Key Loader

This block keeps a volatile secret key that a test-port host loads serially, one bit per test clock. A TAP controller outside the block supplies decoded instruction selects and one-cycle state strobes (capture, shift and update of the data register, instruction update, and logic reset). When the key-program instruction is selected, each shift cycle moves TDI into a key-wide shift chain. The chain has no path to the serial output. An update strobe then commits the chain to the key store, but only if exactly as many bits as the key width were shifted and no valid key is already held. A commit raises a valid flag, and a downstream consumer reads the key together with that flag.

Validity is removed in one of two ways. The first is the clear-verify instruction. Its effect is deliberately slow: the flag drops only after the instruction has stayed selected for a minimum number of consecutive test clocks. A dwell counter measures this and restarts on any instruction update or logic reset. The second is the loading of the unlock instruction, which wipes both the key and the flag at once. While the key-program instruction is selected, the serial output is forced low so that nothing correlated with key traffic leaves the device.

Top module: `vkey_loader`

## Requirements
- R1: After reset `key_valid` is 0, `key_out` is all zeros, and with key-program not selected `tdo_out` equals `tdo_in`.
- R2: A capture strobe under key-program restarts the bit count. If exactly KEY_W shift cycles follow, then an update strobe under key-program while `key_valid` is 0 sets `key_valid` on that edge. `key_out` then holds the shifted bits, with the first bit shifted at bit 0 and the last at bit KEY_W-1.
- R3: If the shift count since the last capture is not exactly KEY_W (fewer or more), an update strobe under key-program leaves `key_valid` at 0 and `key_out` unchanged.
- R4: While `key_valid` is 1, a complete new load under key-program is discarded and `key_out` keeps the stored key.
- R5: While `sel_keyprog` is 1, `tdo_out` is 0 whatever the value of `tdo_in`.
- R6: If `sel_clrver` stays 1 for CLR_DWELL (default 10) consecutive clock edges with no instruction update or logic reset, `key_valid` falls on the last of those edges. `key_out` is not changed, and a new load is accepted afterwards.
- R7: Holding `sel_clrver` for fewer than CLR_DWELL consecutive edges leaves `key_valid` unchanged.
- R8: An `ir_update` or `tap_reset` strobe restarts the dwell count. For example, 5 held edges, then a restart edge, then 5 more held edges do not clear `key_valid`.
- R9: An `unlock_load` strobe sets `key_out` to all zeros and `key_valid` to 0 on that edge.
- R10: Capture, shift and update strobes while `sel_keyprog` is 0 do not change `key_out` or `key_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_tck | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tap_reset | input | 1 | TAP in logic-reset state |
| capture_dr | input | 1 | Capture-DR strobe |
| shift_dr | input | 1 | Shift-DR strobe |
| update_dr | input | 1 | Update-DR strobe |
| ir_update | input | 1 | Update-IR strobe (instruction change) |
| sel_keyprog | input | 1 | Key-program instruction decoded |
| sel_clrver | input | 1 | Clear-verify instruction decoded |
| unlock_load | input | 1 | Unlock instruction loaded strobe |
| tdi | input | 1 | Serial data in |
| tdo_in | input | 1 | Serial output from other data registers |
| tdo_out | output | 1 | Serial data out, masked under key-program |
| key_out | output | KEY_W | Stored key |
| key_valid | output | 1 | Stored key is valid |

## Verification
The assertions rely on the TAP controller to behave normally. At most one of `sel_keyprog` and `sel_clrver` is high at a time. The capture, shift and update strobes are never high together, and each strobe lasts a single clock. The bench drives every input on the falling edge and pulses each strobe for exactly one cycle. It never selects both instructions at once, and it holds `sel_clrver` steady during a dwell except where a restart strobe is the thing under test.

// File: rtl/vkey_pkg.sv
package vkey_pkg;

  // Saturating increment: stops at lim.
  function automatic int unsigned sat_inc(input int unsigned v, input int unsigned lim);
    return (v >= lim) ? lim : v + 1;
  endfunction

  // A load is complete when the count equals the key width exactly.
  function automatic logic load_complete(input int unsigned cnt, input int unsigned width);
    return cnt == width;
  endfunction

  // Dwell reaches its limit on the edge where the pre-edge count is lim-1.
  function automatic logic dwell_done(input int unsigned cnt, input int unsigned lim);
    return cnt == lim - 1;
  endfunction

endpackage

// File: rtl/vkey_shift.sv
module vkey_shift #(
  parameter int KEY_W = 512,
  localparam int CW = $clog2(KEY_W + 2)
) (
  input  logic             clk_tck,
  input  logic             rst_n,
  input  logic             tap_reset,
  input  logic             capture_dr,
  input  logic             shift_dr,
  input  logic             sel_keyprog,
  input  logic             tdi,
  output logic [KEY_W-1:0] chain,
  output logic [CW-1:0]    bit_cnt
);
  import vkey_pkg::*;

  localparam int unsigned CNT_SAT = KEY_W + 1;

  logic do_shift;
  logic do_restart;

  assign do_shift   = shift_dr && sel_keyprog;
  assign do_restart = tap_reset || (capture_dr && sel_keyprog);

  // Chain fills from the top so the first bit lands at bit 0.
  always_ff @(posedge clk_tck or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
    end else if (do_shift) begin
      chain <= {tdi, chain[KEY_W-1:1]};
    end
  end

  always_ff @(posedge clk_tck or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
    end else if (do_restart) begin
      bit_cnt <= '0;
    end else if (do_shift) begin
      bit_cnt <= CW'(sat_inc(int'(bit_cnt), CNT_SAT));
    end
  end

endmodule

// File: rtl/vkey_dwell.sv
module vkey_dwell #(
  parameter int CLR_DWELL = 10,
  localparam int DW = $clog2(CLR_DWELL + 1)
) (
  input  logic          clk_tck,
  input  logic          rst_n,
  input  logic          tap_reset,
  input  logic          ir_update,
  input  logic          sel_clrver,
  output logic [DW-1:0] dwell_cnt,
  output logic          clear_ev
);
  import vkey_pkg::*;

  logic restart;

  assign restart  = tap_reset || ir_update || !sel_clrver;
  assign clear_ev = !restart && dwell_done(int'(dwell_cnt), CLR_DWELL);

  always_ff @(posedge clk_tck or negedge rst_n) begin
    if (!rst_n) begin
      dwell_cnt <= '0;
    end else if (restart) begin
      dwell_cnt <= '0;
    end else begin
      dwell_cnt <= DW'(sat_inc(int'(dwell_cnt), CLR_DWELL));
    end
  end

endmodule

// File: rtl/vkey_store.sv
module vkey_store #(
  parameter int KEY_W = 512
) (
  input  logic             clk_tck,
  input  logic             rst_n,
  input  logic             unlock_load,
  input  logic             clear_ev,
  input  logic             accept_req,
  input  logic [KEY_W-1:0] chain,
  output logic [KEY_W-1:0] key_q,
  output logic             valid_q,
  output logic             commit_ev
);

  // A request is honoured only while no valid key is held.
  assign commit_ev = accept_req && !valid_q && !unlock_load && !clear_ev;

  always_ff @(posedge clk_tck or negedge rst_n) begin
    if (!rst_n) begin
      key_q   <= '0;
      valid_q <= 1'b0;
    end else if (unlock_load) begin
      key_q   <= '0;
      valid_q <= 1'b0;
    end else if (clear_ev) begin
      valid_q <= 1'b0;
    end else if (commit_ev) begin
      key_q   <= chain;
      valid_q <= 1'b1;
    end
  end

endmodule

// File: rtl/vkey_loader.sv
module vkey_loader #(
  parameter int KEY_W     = 512,
  parameter int CLR_DWELL = 10
) (
  input  logic             clk_tck,
  input  logic             rst_n,
  input  logic             tap_reset,
  input  logic             capture_dr,
  input  logic             shift_dr,
  input  logic             update_dr,
  input  logic             ir_update,
  input  logic             sel_keyprog,
  input  logic             sel_clrver,
  input  logic             unlock_load,
  input  logic             tdi,
  input  logic             tdo_in,
  output logic             tdo_out,
  output logic [KEY_W-1:0] key_out,
  output logic             key_valid
);
  import vkey_pkg::*;

  localparam int CW = $clog2(KEY_W + 2);
  localparam int DW = $clog2(CLR_DWELL + 1);

  logic [KEY_W-1:0] chain;
  logic [CW-1:0]    bit_cnt;
  logic [DW-1:0]    dwell_cnt;
  logic             clear_ev;
  logic             commit_ev;
  logic             accept_req;

  vkey_shift #(.KEY_W(KEY_W)) u_shift (
    .clk_tck     (clk_tck),
    .rst_n       (rst_n),
    .tap_reset   (tap_reset),
    .capture_dr  (capture_dr),
    .shift_dr    (shift_dr),
    .sel_keyprog (sel_keyprog),
    .tdi         (tdi),
    .chain       (chain),
    .bit_cnt     (bit_cnt)
  );

  vkey_dwell #(.CLR_DWELL(CLR_DWELL)) u_dwell (
    .clk_tck    (clk_tck),
    .rst_n      (rst_n),
    .tap_reset  (tap_reset),
    .ir_update  (ir_update),
    .sel_clrver (sel_clrver),
    .dwell_cnt  (dwell_cnt),
    .clear_ev   (clear_ev)
  );

  assign accept_req = update_dr && sel_keyprog && load_complete(int'(bit_cnt), KEY_W);

  vkey_store #(.KEY_W(KEY_W)) u_store (
    .clk_tck     (clk_tck),
    .rst_n       (rst_n),
    .unlock_load (unlock_load),
    .clear_ev    (clear_ev),
    .accept_req  (accept_req),
    .chain       (chain),
    .key_q       (key_out),
    .valid_q     (key_valid),
    .commit_ev   (commit_ev)
  );

  // The key chain never reaches the serial output; mask it while selected.
  assign tdo_out = sel_keyprog ? 1'b0 : tdo_in;

endmodule

// File: rtl/vkey_loader_chk.sv
module vkey_loader_chk #(
  parameter int KEY_W     = 512,
  parameter int CLR_DWELL = 10
) (
  input logic             clk_tck,
  input logic             rst_n,
  input logic             tap_reset,
  input logic             update_dr,
  input logic             ir_update,
  input logic             sel_keyprog,
  input logic             sel_clrver,
  input logic             unlock_load,
  input logic             tdo_out,
  input logic [KEY_W-1:0] key_out,
  input logic             key_valid,
  input logic             clear_ev,
  input logic             commit_ev
);
  localparam int HW = $clog2(CLR_DWELL + 2);

  // Independent count of consecutive held clear-verify edges.
  logic [HW-1:0] held;
  always_ff @(posedge clk_tck or negedge rst_n) begin
    if (!rst_n) held <= '0;
    else if (!sel_clrver || ir_update || tap_reset) held <= '0;
    else if (held <= HW'(CLR_DWELL)) held <= held + 1'b1;
  end

  p_tdo_quiet_r5: assert property (@(posedge clk_tck) disable iff (!rst_n)
    sel_keyprog |-> !tdo_out);

  p_valid_rise_r2: assert property (@(posedge clk_tck) disable iff (!rst_n)
    $rose(key_valid) |-> $past(update_dr && sel_keyprog));

  p_key_kept_r4: assert property (@(posedge clk_tck) disable iff (!rst_n)
    (key_valid && !unlock_load) |=> $stable(key_out));

  p_unlock_wipe_r9: assert property (@(posedge clk_tck) disable iff (!rst_n)
    unlock_load |=> (!key_valid && key_out == '0));

  p_valid_fall_r6: assert property (@(posedge clk_tck) disable iff (!rst_n)
    $fell(key_valid) |-> ($past(unlock_load) || $past(clear_ev)));

  p_dwell_min_r7: assert property (@(posedge clk_tck) disable iff (!rst_n)
    clear_ev |-> (held >= HW'(CLR_DWELL - 1)));

  p_dwell_fire_r8: assert property (@(posedge clk_tck) disable iff (!rst_n)
    (sel_clrver && !ir_update && !tap_reset && held == HW'(CLR_DWELL - 1))
      |=> !key_valid);

  p_commit_gate_r4: assert property (@(posedge clk_tck) disable iff (!rst_n)
    commit_ev |-> !key_valid);

endmodule

bind vkey_loader vkey_loader_chk #(.KEY_W(KEY_W), .CLR_DWELL(CLR_DWELL)) u_chk (
  .clk_tck     (clk_tck),
  .rst_n       (rst_n),
  .tap_reset   (tap_reset),
  .update_dr   (update_dr),
  .ir_update   (ir_update),
  .sel_keyprog (sel_keyprog),
  .sel_clrver  (sel_clrver),
  .unlock_load (unlock_load),
  .tdo_out     (tdo_out),
  .key_out     (key_out),
  .key_valid   (key_valid),
  .clear_ev    (clear_ev),
  .commit_ev   (commit_ev)
);

// File: tb/test_vkey_loader.sv
module test_vkey_loader;
  localparam int KEY_W     = 512;
  localparam int CLR_DWELL = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tap_reset = 0, capture_dr = 0, shift_dr = 0, update_dr = 0, ir_update = 0;
  logic sel_keyprog = 0, sel_clrver = 0, unlock_load = 0, tdi = 0, tdo_in = 0;
  logic tdo_out;
  logic [KEY_W-1:0] key_out;
  logic key_valid;

  always #2 clk = ~clk;

  vkey_loader #(.KEY_W(KEY_W), .CLR_DWELL(CLR_DWELL)) i_vkey_loader (
    .clk_tck(clk), .rst_n(rst_n), .tap_reset(tap_reset), .capture_dr(capture_dr),
    .shift_dr(shift_dr), .update_dr(update_dr), .ir_update(ir_update),
    .sel_keyprog(sel_keyprog), .sel_clrver(sel_clrver), .unlock_load(unlock_load),
    .tdi(tdi), .tdo_in(tdo_in), .tdo_out(tdo_out), .key_out(key_out), .key_valid(key_valid)
  );

  typedef struct {
    string            tag;
    logic             valid;
    logic [KEY_W-1:0] key;
    logic             tdo;
  } item_t;

  item_t sb_q[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  // Monitor: compare queued expectations a moment after the falling edge.
  always @(negedge clk) begin
    #1;
    while (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      n_cmp++;
      if (key_valid !== it.valid || key_out !== it.key || tdo_out !== it.tdo) begin
        n_bad++;
        $display("FAIL %s: valid=%0b key[31:0]=%h tdo=%0b, expected valid=%0b key[31:0]=%h tdo=%0b",
                 it.tag, key_valid, key_out[31:0], tdo_out, it.valid, it.key[31:0], it.tdo);
      end
    end
  end

  task automatic expect_now(input string tag, input logic v, input logic [KEY_W-1:0] k,
                            input logic t);
    item_t it;
    it.tag = tag; it.valid = v; it.key = k; it.tdo = t;
    sb_q.push_back(it);
    @(negedge clk);
  endtask

  function automatic logic [KEY_W-1:0] make_key(input int seed);
    logic [KEY_W-1:0] k;
    for (int w = 0; w < KEY_W / 32; w++) k[w*32 +: 32] = $urandom(seed + w) ^ (32'h9e37_79b9 * (w + 1));
    return k;
  endfunction

  // Driver: capture, nbits shifts (bit i of k, wrapping), update.
  task automatic load_key(input logic [KEY_W-1:0] k, input int nbits, input logic sel);
    sel_keyprog = sel;
    capture_dr = 1; @(negedge clk); capture_dr = 0;
    for (int i = 0; i < nbits; i++) begin
      shift_dr = 1; tdi = k[i % KEY_W]; @(negedge clk);
    end
    shift_dr = 0;
    update_dr = 1; @(negedge clk); update_dr = 0;
    sel_keyprog = 0;
  endtask

  task automatic hold_clear(input int edges);
    sel_clrver = 1;
    for (int i = 0; i < edges; i++) @(negedge clk);
    sel_clrver = 0;
  endtask

  logic [KEY_W-1:0] k1, k2, k3;

  initial begin
    k1 = make_key(11); k2 = make_key(222); k3 = make_key(3333);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    tdo_in = 1;
    expect_now("R1 reset state", 0, '0, 1);
    sel_keyprog = 1;
    expect_now("R5 tdo masked", 0, '0, 0);
    sel_keyprog = 0;

    load_key(k1, KEY_W - 1, 1);
    expect_now("R3 short load", 0, '0, 1);
    load_key(k1, KEY_W + 1, 1);
    expect_now("R3 long load", 0, '0, 1);
    load_key(k1, KEY_W, 0);
    expect_now("R10 strobes unselected", 0, '0, 1);

    load_key(k1, KEY_W, 1);
    expect_now("R2 exact load", 1, k1, 1);
    load_key(k2, KEY_W, 1);
    expect_now("R4 reload discarded", 1, k1, 1);

    hold_clear(CLR_DWELL - 1);
    expect_now("R7 short dwell", 1, k1, 1);

    sel_clrver = 1;
    repeat (5) @(negedge clk);
    ir_update = 1; @(negedge clk); ir_update = 0;
    repeat (5) @(negedge clk);
    sel_clrver = 0;
    expect_now("R8 restart by ir_update", 1, k1, 1);

    sel_clrver = 1;
    repeat (5) @(negedge clk);
    tap_reset = 1; @(negedge clk); tap_reset = 0;
    repeat (5) @(negedge clk);
    sel_clrver = 0;
    expect_now("R8 restart by tap_reset", 1, k1, 1);

    hold_clear(CLR_DWELL);
    expect_now("R6 full dwell clears", 0, k1, 1);

    load_key(k2, KEY_W, 1);
    expect_now("R6 reload after clear", 1, k2, 1);

    unlock_load = 1; @(negedge clk); unlock_load = 0;
    expect_now("R9 unlock wipe", 0, '0, 1);

    load_key(k3, KEY_W, 1);
    tdo_in = 0;
    expect_now("R2 load after unlock", 1, k3, 0);

    @(negedge clk); @(negedge clk);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule